// File: doc/BRIEF.md
# Four-Lane Multi-Format PCM Audio Serializer

This block turns parallel PCM samples into a master-mode serial audio stream. Eight channel samples arrive together, one set per frame, and leave on four serial data lines, each line carrying one stereo pair. All four lines share a single bit clock and a single left/right word clock, and the block generates both itself by dividing the master clock that drives it.

Three framings are supported: standard I2S, where the first data bit lags the word-clock edge by one bit clock; left-justified, where the first bit lines up with that edge; and right-justified, where the last bit of the word sits just before the next word-clock edge. Samples can be 16, 20 or 24 bits wide inside a fixed 32-slot half frame. The sample source sees a one-cycle ready pulse at every frame start. If it has nothing new, the previous samples are sent again. Format, width and clock ratio are taken at frame boundaries only, so a change written mid-frame never corrupts the frame in progress.

Top module: `audio_ser_top`

## Requirements
- R1: Data line p (0..3) carries channel 2p while the word clock is low and channel 2p+1 while it is high. Channel c occupies `smp_data[24c+23:24c]`, and the sample is the low W bits of that field.
- R2: `bclk` has a period of 2*N master-clock cycles and a 50% duty cycle, where N is `bclk_div`. A value of 0 is treated as 1.
- R3: Each word-clock half lasts exactly 32 bit clocks. The word clock is low for the left channel and high for the right channel.
- R4: With `fmt_sel` equal to 0 (or 3), the MSB of a word occupies slot 1 of its half, one bit clock after the word-clock edge.
- R5: With `fmt_sel` equal to 1, the MSB occupies slot 0 and coincides with the word-clock edge.
- R6: With `fmt_sel` equal to 2, the LSB occupies slot 31, the last slot before the next word-clock edge.
- R7: `width_sel` codes 0, 1 and 2 select 16, 20 and 24 bits, and code 3 means 24. Every slot that does not hold a sample bit outputs 0.
- R8: `lrclk` and every `sdata` line change only in the master-clock cycle in which `bclk` falls.
- R9: `smp_ready` is a single-cycle pulse in the cycle before the falling `bclk` that starts a frame (the left half). The samples are taken when `smp_valid` is high in that cycle. Otherwise the previous eight samples are repeated.
- R10: `fmt_sel`, `width_sel` and `bclk_div` are sampled during reset and at each frame boundary (the `smp_ready` cycle) only.
- R11: During reset and right after it, `bclk` is 0, `lrclk` is 1 and every `sdata` line is 0. The first frame starts on the first falling `bclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 I2S |
| width_sel | input | 2 | Sample width: 0=16, 1=20, 2/3=24 bits |
| bclk_div | input | DIVW (8) | Bit-clock half period in master-clock cycles |
| smp_data | input | 2*NLINE*24 (192) | Eight channel samples, channel c at bits 24c+23:24c |
| smp_valid | input | 1 | New samples are available |
| smp_ready | output | 1 | Frame-start pulse; samples are taken when valid |
| bclk | output | 1 | Serial bit clock |
| lrclk | output | 1 | Word clock, low for left |
| sdata | output | NLINE (4) | Serial data lines, one stereo pair each |

## Verification
The assertions assume that reset is held for at least one clock, and that the sample source looks at `smp_ready` only in the cycle in which it is high, holding `smp_valid` and `smp_data` steady through that cycle. The stimulus meets this by changing the samples and the configuration only in the cycle after each ready pulse. Because of that timing, every new configuration arrives mid-frame and has to wait for the next boundary. The sweep covers all format, width and divider codes, including the aliased codes and a divider of 0. Every fifth frame has `smp_valid` low to exercise the repeat path.

// File: rtl/audio_ser_pkg.sv
package audio_ser_pkg;

    localparam int MAXW  = 24;
    localparam int SLOTS = 32;

    typedef enum logic [1:0] {
        FMT_I2S     = 2'd0,
        FMT_LEFT    = 2'd1,
        FMT_RIGHT   = 2'd2,
        FMT_I2S_ALT = 2'd3
    } fmt_e;

    typedef struct packed {
        fmt_e       fmt;
        logic [1:0] wsel;
    } frame_cfg_t;

    function automatic logic [5:0] word_len(input logic [1:0] wsel);
        case (wsel)
            2'd0:    return 6'd16;
            2'd1:    return 6'd20;
            default: return 6'd24;
        endcase
    endfunction

    // Bit driven in one slot of a half frame for a given framing and width.
    function automatic logic slot_bit(input fmt_e fmt, input logic [1:0] wsel,
                                      input logic [4:0] slot,
                                      input logic [MAXW-1:0] smp);
        logic [5:0] w;
        logic [5:0] off;
        logic [5:0] pos;
        logic [5:0] k;
        logic [5:0] idx;
        w = word_len(wsel);
        case (fmt)
            FMT_LEFT:  off = 6'd0;
            FMT_RIGHT: off = 6'(SLOTS) - w;
            default:   off = 6'd1;
        endcase
        pos = {1'b0, slot};
        k   = pos - off;
        idx = w - 6'd1 - k;
        if (pos < off || k >= w) return 1'b0;
        return smp[idx[4:0]];
    endfunction

endpackage

// File: rtl/ser_clkgen.sv
module ser_clkgen #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DIVW-1:0] divh,
    output logic            bclk,
    output logic            fall_evt
);
    logic [DIVW-1:0] cnt_q;
    logic [DIVW-1:0] lim;
    logic            bclk_q;
    logic            tick;

    assign lim      = (divh == '0) ? DIVW'(1) : divh;
    assign tick     = (cnt_q == lim - DIVW'(1));
    assign fall_evt = tick & bclk_q;
    assign bclk     = bclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            bclk_q <= 1'b0;
        end else if (tick) begin
            cnt_q  <= '0;
            bclk_q <= ~bclk_q;
        end else begin
            cnt_q  <= cnt_q + DIVW'(1);
        end
    end

    // R2: the phase counter never passes the half-period limit
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q < lim);

    // R2: the clock only toggles when the counter has expired
    p_toggle_tick_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(bclk_q));

endmodule

// File: rtl/ser_frame.sv
module ser_frame
    import audio_ser_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int DIVW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fall_evt,
    input  logic [1:0]          fmt_in,
    input  logic [1:0]          wsel_in,
    input  logic [DIVW-1:0]     divh_in,
    input  logic [NCH*MAXW-1:0] smp_data,
    input  logic                smp_valid,
    output logic                smp_ready,
    output logic [DIVW-1:0]     divh_cur,
    output frame_cfg_t          cfg_nxt,
    output logic [NCH*MAXW-1:0] data_nxt,
    output logic [5:0]          pos_nxt,
    output logic                lrclk
);
    localparam logic [5:0] LAST_SLOT = 6'(2 * SLOTS - 1);

    frame_cfg_t          cfg_q;
    logic [DIVW-1:0]     divh_q;
    logic [DIVW-1:0]     divh_nxt;
    logic [NCH*MAXW-1:0] data_q;
    logic [5:0]          pos_q;
    logic                lr_q;
    logic                wrap;
    logic                accept;

    assign wrap      = fall_evt && (pos_q == LAST_SLOT);
    assign accept    = wrap && smp_valid;
    assign smp_ready = wrap;
    assign divh_cur  = divh_q;
    assign lrclk     = lr_q;
    assign pos_nxt   = pos_q + 6'd1;

    always_comb begin
        cfg_nxt  = cfg_q;
        divh_nxt = divh_q;
        if (wrap) begin
            cfg_nxt  = '{fmt: fmt_e'(fmt_in), wsel: wsel_in};
            divh_nxt = divh_in;
        end
        data_nxt = accept ? smp_data : data_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= LAST_SLOT;
            lr_q   <= 1'b1;
            cfg_q  <= '{fmt: fmt_e'(fmt_in), wsel: wsel_in};
            divh_q <= divh_in;
            data_q <= '0;
        end else if (fall_evt) begin
            pos_q  <= pos_nxt;
            lr_q   <= pos_nxt[5];
            cfg_q  <= cfg_nxt;
            divh_q <= divh_nxt;
            data_q <= data_nxt;
        end
    end

    // R3: the word clock flips only at the first slot of a half
    p_lr_slot_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(lr_q) |-> (pos_q == 6'd0 || pos_q == 6'd32));

    // R10: configuration holds between frame boundaries
    p_cfg_frame_r10: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> ($stable(cfg_q) && $stable(divh_q)));

    // R9: a boundary without valid samples keeps the previous set
    p_repeat_r9: assert property (@(posedge clk) disable iff (rst)
        (wrap && !smp_valid) |=> $stable(data_q));

endmodule

// File: rtl/ser_lane.sv
module ser_lane
    import audio_ser_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            fall_evt,
    input  frame_cfg_t      cfg_nxt,
    input  logic [5:0]      pos_nxt,
    input  logic [MAXW-1:0] left_smp,
    input  logic [MAXW-1:0] right_smp,
    output logic            sd
);
    logic            sd_q;
    logic [MAXW-1:0] cur_smp;

    assign cur_smp = pos_nxt[5] ? right_smp : left_smp;
    assign sd      = sd_q;

    always_ff @(posedge clk) begin
        if (rst)
            sd_q <= 1'b0;
        else if (fall_evt)
            sd_q <= slot_bit(cfg_nxt.fmt, cfg_nxt.wsel, pos_nxt[4:0], cur_smp);
    end

    // R8: a data line moves only on a falling bit-clock event
    p_sd_fall_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(sd_q) |-> $past(fall_evt));

endmodule

// File: rtl/audio_ser_top.sv
module audio_ser_top
    import audio_ser_pkg::*;
#(
    parameter int NLINE = 4,
    parameter int DIVW  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              fmt_sel,
    input  logic [1:0]              width_sel,
    input  logic [DIVW-1:0]         bclk_div,
    input  logic [2*NLINE*MAXW-1:0] smp_data,
    input  logic                    smp_valid,
    output logic                    smp_ready,
    output logic                    bclk,
    output logic                    lrclk,
    output logic [NLINE-1:0]        sdata
);
    localparam int NCH = 2 * NLINE;

    logic                fall_evt;
    logic [DIVW-1:0]     divh_cur;
    frame_cfg_t          cfg_nxt;
    logic [NCH*MAXW-1:0] data_nxt;
    logic [5:0]          pos_nxt;

    ser_clkgen #(.DIVW(DIVW)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .divh     (divh_cur),
        .bclk     (bclk),
        .fall_evt (fall_evt)
    );

    ser_frame #(.NCH(NCH), .DIVW(DIVW)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .fall_evt  (fall_evt),
        .fmt_in    (fmt_sel),
        .wsel_in   (width_sel),
        .divh_in   (bclk_div),
        .smp_data  (smp_data),
        .smp_valid (smp_valid),
        .smp_ready (smp_ready),
        .divh_cur  (divh_cur),
        .cfg_nxt   (cfg_nxt),
        .data_nxt  (data_nxt),
        .pos_nxt   (pos_nxt),
        .lrclk     (lrclk)
    );

    for (genvar p = 0; p < NLINE; p++) begin : g_lane
        ser_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .fall_evt  (fall_evt),
            .cfg_nxt   (cfg_nxt),
            .pos_nxt   (pos_nxt),
            .left_smp  (data_nxt[(2*p)*MAXW +: MAXW]),
            .right_smp (data_nxt[(2*p+1)*MAXW +: MAXW]),
            .sd        (sdata[p])
        );
    end

    // R8: word clock moves together with a falling bit clock
    p_lr_fall_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(lrclk) |-> $fell(bclk));

    // R9: the ready pulse precedes the falling edge that opens a left half
    p_ready_start_r9: assert property (@(posedge clk) disable iff (rst)
        smp_ready |=> ($fell(bclk) && !lrclk));

    // R9: ready is a single-cycle pulse
    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        smp_ready |=> !smp_ready);

endmodule

// File: tb/tb_audio_ser_top.sv
module tb_audio_ser_top;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   fmt_sel;
    logic [1:0]   width_sel;
    logic [7:0]   bclk_div;
    logic [191:0] smp_data;
    logic         smp_valid;
    logic         smp_ready;
    logic         bclk;
    logic         lrclk;
    logic [3:0]   sdata;

    always #2 clk = ~clk;

    audio_ser_top dut (
        .clk       (clk),
        .rst       (rst),
        .fmt_sel   (fmt_sel),
        .width_sel (width_sel),
        .bclk_div  (bclk_div),
        .smp_data  (smp_data),
        .smp_valid (smp_valid),
        .smp_ready (smp_ready),
        .bclk      (bclk),
        .lrclk     (lrclk),
        .sdata     (sdata)
    );

    int  errs   = 0;
    int  checks = 0;
    bit  done   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    function automatic logic [191:0] pat(input int n);
        logic [191:0] v;
        for (int c = 0; c < 8; c++)
            v[c*24 +: 24] = 24'(n * 24'h1357B + c * 24'h2E5D1 + 24'hA5C3);
        return v;
    endfunction

    function automatic bit exp_bit(input logic [1:0] f, input logic [1:0] w,
                                   input int slot, input logic [23:0] val);
        int wl;
        int off;
        int k;
        wl  = (w == 2'd0) ? 16 : (w == 2'd1) ? 20 : 24;
        off = (f == 2'd1) ? 0 : (f == 2'd2) ? 32 - wl : 1;
        k   = (slot % 32) - off;
        if (k < 0 || k >= wl) return 1'b0;
        return val[wl - 1 - k];
    endfunction

    // monitor state
    bit           mon_en  = 0;
    bit           started = 0;
    bit           pend    = 0;
    logic [1:0]   c_fmt;
    logic [1:0]   c_w;
    int           c_div;
    bit           c_valid;
    logic [191:0] c_data = '0;
    int           slot    = 0;
    int           hi_cnt  = 0;
    int           lo_cnt  = 0;
    logic         prev_b, prev_lr, prev_rdy;
    logic [3:0]   prev_sd;

    always @(negedge clk) begin
        if (mon_en) begin
            bit fell;
            bit rose;
            string tag;
            fell = prev_b && !bclk;
            rose = !prev_b && bclk;
            if (lrclk !== prev_lr || sdata !== prev_sd)
                chk(fell, "R8", "output moved without falling bclk", 0, 1);
            if (fell) begin
                if (pend) begin
                    if (started)
                        chk(slot == 63, "R3", "bit clocks per frame minus one", slot, 63);
                    slot = 0; pend = 0; started = 1;
                end else begin
                    slot++;
                end
                if (started) begin
                    if (slot != 0)
                        chk(hi_cnt == c_div, "R2", "bclk high cycles", hi_cnt, c_div);
                    chk(lrclk == (slot >= 32), "R3", "lrclk level for slot", lrclk, slot >= 32);
                    tag = (c_fmt == 2'd1) ? "R5" : (c_fmt == 2'd2) ? "R6" : "R4";
                    tag = {"R1 ", tag, " R7 R10", c_valid ? "" : " R9"};
                    for (int p = 0; p < 4; p++) begin
                        int ch;
                        bit e;
                        ch = 2 * p + ((slot >= 32) ? 1 : 0);
                        e  = exp_bit(c_fmt, c_w, slot, c_data[ch*24 +: 24]);
                        chk(sdata[p] == e, tag, $sformatf("line %0d slot %0d", p, slot),
                            sdata[p], e);
                    end
                end
                lo_cnt = 1;
            end else if (rose) begin
                if (started)
                    chk(lo_cnt == c_div, "R2", "bclk low cycles", lo_cnt, c_div);
                hi_cnt = 1;
            end else if (bclk) begin
                hi_cnt++;
            end else begin
                lo_cnt++;
            end
            if (smp_ready) begin
                chk(!prev_rdy, "R9", "ready longer than one cycle", prev_rdy, 0);
                chk(bclk == 1'b1, "R9", "ready while bclk high", bclk, 1);
                c_fmt   = fmt_sel;
                c_w     = width_sel;
                c_div   = (bclk_div == 0) ? 1 : int'(bclk_div);
                c_valid = smp_valid;
                if (smp_valid) c_data = smp_data;
                pend = 1;
            end
        end
        prev_b   = bclk;
        prev_lr  = lrclk;
        prev_sd  = sdata;
        prev_rdy = smp_ready;
    end

    task automatic wait_ready();
        @(negedge clk);
        while (!smp_ready) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        int fidx;
        rst       = 1'b1;
        fmt_sel   = 2'd0;
        width_sel = 2'd2;
        bclk_div  = 8'd2;
        smp_valid = 1'b1;
        smp_data  = pat(0);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        #0;
        chk(bclk == 1'b0,   "R11", "bclk after reset",  bclk, 0);
        chk(lrclk == 1'b1,  "R11", "lrclk after reset", lrclk, 1);
        chk(sdata == 4'h0,  "R11", "sdata after reset", sdata, 0);
        prev_b   = bclk;
        prev_lr  = lrclk;
        prev_sd  = sdata;
        prev_rdy = smp_ready;
        mon_en   = 1;
        fidx     = 1;
        for (int m = 0; m < 4; m++) begin
            for (int w = 0; w < 4; w++) begin
                for (int d = 0; d < 4; d++) begin
                    for (int f = 0; f < 3; f++) begin
                        wait_ready();
                        @(negedge clk);
                        smp_data  = pat(fidx);
                        smp_valid = (fidx % 5) != 0;
                        if (f == 0) begin
                            fmt_sel   = 2'(m);
                            width_sel = 2'(w);
                            bclk_div  = 8'(d);
                        end
                        fidx++;
                    end
                end
            end
        end
        wait_ready();
        wait_ready();
        finish_run();
    end

endmodule